// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that lets a host controller read and rewrite a small bank of byte-wide configuration registers. In a clock fan-out device, for example, each bit could enable one output. The block samples SCL and SDA with the system clock and drives SDA open-drain through separate output-enable and output pins. It answers a single fixed device address, 0xDC for writes and 0xDD for reads. The register bank sits on a parallel bus that downstream logic reads directly.

Every register leaves reset holding a fixed default, so a system that never touches the serial port still works. A command byte chooses the access type. With its top bit set, it picks one register by index for a single-byte access. With its top bit clear, it opens a block access that walks the bank upward from offset zero. A block write sends a byte count first. A block read returns the bank size first.

The downstream bus is a level-valued register image with no handshake. A register changes on the system clock edge that follows receipt of its last data bit. The serial side has no back-pressure of its own: the host paces every transfer with SCL.

Top module: `cfgreg_smbus_slave`

## Requirements
- R1: After reset, `cfg_o` holds the parameter `RST_VAL`, with register i in bits [8i+7:8i].
- R2: The slave pulls SDA low in the acknowledge slot of an address byte whose upper seven bits equal `DEV_ADDR` (the bytes 0xDC and 0xDD by default). For any other address it does not acknowledge, drives nothing and ignores all traffic until the next START.
- R3: Byte write: a command byte with bit 7 = 1 takes its offset from bits 6:0. The next byte is stored in that register, and every other register keeps its value.
- R4: Byte read: after a byte-mode command byte, a repeated START and address 0xDD, the slave returns the indexed register most significant bit first.
- R5: Block write: a command byte with bit 7 = 0 starts at offset 0, whatever bits 6:0 hold. The next byte is a count and is not stored. The data bytes after it go to offsets 0, 1, 2 and so on.
- R6: A STOP after any complete data byte of a block write ends the transfer. The registers already written keep their new values, and the rest keep their old ones.
- R7: Block read: the slave first returns the bank size (`NUM_REGS`), then registers from offset 0 upward, one per byte the master acknowledges. A master NACK ends the read and releases SDA.
- R8: Offsets at or beyond `NUM_REGS` are acknowledged but not stored, and reads of them return 0xFF. This covers byte writes to such an offset and block write bytes past the top of the bank.
- R9: The slave changes its SDA drive only while the synchronized SCL is low. It acknowledges by holding SDA low for the whole ninth clock of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Serial data as seen at the pad |
| sda_o | output | 1 | Data output level, tied low (open-drain) |
| sda_oe | output | 1 | High when the slave pulls SDA low |
| cfg_o | output | 8*NUM_REGS | Parallel image of the register bank |

## Verification
Two things can land on the same system clock edge. One is the commit of a block-write data byte into the top register. The other is the pointer stepping past the end of the bank, which must make the next byte a discard rather than a wrap to offset 0. The bench provokes this by running block writes of every length from zero to two bytes past the bank size. After each one it compares the whole `cfg_o` image against an arithmetic model. A short transfer shows that the untouched registers stayed put, and an overlong one shows that register 0 was not overwritten.

// File: rtl/cfgsmb_pkg.sv
package cfgsmb_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned OFS_W    = 7;
  localparam int unsigned BITCNT_W = 4;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_CMD,
    XS_CNT,
    XS_WDAT,
    XS_TX
  } xact_st_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges while the clock line stays high frame a transaction
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter logic [8*NUM_REGS-1:0] RST_VAL = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [6:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_o[8*i +: 8] <= RST_VAL[8*i +: 8];
        else if (wr_en && (wr_addr == 7'(i)))
          cfg_o[8*i +: 8] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == 7'(i)) rd_data = cfg_o[8*i +: 8];
  end
endmodule

// File: rtl/smb_xact_engine.sv
module smb_xact_engine
  import cfgsmb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h6E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                sda_s,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [7:0]          rd_data,
  output logic [6:0]          ptr,
  output logic                wr_en,
  output logic [6:0]          wr_addr,
  output logic [7:0]          wr_data,
  output logic                drive_low,
  output xact_st_t            state,
  output logic [BITCNT_W-1:0] bit_cnt
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  xact_st_t   nxt_q;
  logic [7:0] rx_sh, tx_sh;
  logic       ack_go, blk, cnt_sent;
  logic [7:0] rx_byte, tx_next;
  logic       ptr_in;

  assign rx_byte = {rx_sh[6:0], sda_s};
  assign ptr_in  = {1'b0, ptr} < NREG8;
  assign tx_next = (blk && !cnt_sent) ? NREG8 : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      nxt_q     <= XS_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ack_go    <= 1'b0;
      blk       <= 1'b0;
      cnt_sent  <= 1'b0;
      ptr       <= '0;
      drive_low <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state     <= XS_ADDR;
        nxt_q     <= XS_ADDR;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
        ack_go    <= 1'b0;
      end else if (stop_det) begin
        state     <= XS_IDLE;
        drive_low <= 1'b0;
      end else if (state != XS_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (state != XS_TX) begin
              rx_sh <= rx_byte;
              if (bit_cnt == 4'd7) begin
                ack_go <= 1'b1;
                case (state)
                  XS_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR)
                      nxt_q <= rx_byte[0] ? XS_TX : XS_CMD;
                    else begin
                      state  <= XS_IDLE;
                      ack_go <= 1'b0;
                    end
                  end
                  XS_CMD: begin
                    blk      <= ~rx_byte[7];
                    ptr      <= rx_byte[7] ? rx_byte[6:0] : 7'd0;
                    cnt_sent <= 1'b0;
                    nxt_q    <= rx_byte[7] ? XS_WDAT : XS_CNT;
                  end
                  XS_CNT: nxt_q <= XS_WDAT;
                  XS_WDAT: begin
                    wr_en   <= ptr_in;
                    wr_addr <= ptr;
                    wr_data <= rx_byte;
                    if (ptr_in) ptr <= ptr + 7'd1;
                    nxt_q   <= XS_WDAT;
                  end
                  default: ;
                endcase
              end
            end
          end else begin
            bit_cnt <= 4'd9;
            // master acknowledge slot of a transmitted byte
            if (state == XS_TX && sda_s) begin
              state     <= XS_IDLE;
              drive_low <= 1'b0;
            end
          end
        end else if (scl_fall) begin
          if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            state   <= nxt_q;
            ack_go  <= 1'b0;
            if (nxt_q == XS_TX) begin
              tx_sh     <= tx_next;
              drive_low <= ~tx_next[7];
              if (blk && !cnt_sent) cnt_sent <= 1'b1;
              else if (ptr_in)      ptr      <= ptr + 7'd1;
            end else begin
              drive_low <= 1'b0;
            end
          end else if (bit_cnt == 4'd8) begin
            drive_low <= (state == XS_TX) ? 1'b0 : ack_go;
          end else if (state == XS_TX && bit_cnt != 4'd0) begin
            drive_low <= ~tx_sh[3'd7 - bit_cnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgreg_smbus_slave.sv
module cfgreg_smbus_slave
  import cfgsmb_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter logic [6:0]  DEV_ADDR    = 7'h6E,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [8*NUM_REGS-1:0] RST_VAL = {NUM_REGS{8'hFF}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_o,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] ptr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en, drive_low;
  xact_st_t st;
  logic [BITCNT_W-1:0] bit_cnt;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_xact_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .drive_low(drive_low), .state(st), .bit_cnt(bit_cnt)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .cfg_o(cfg_o)
  );

  assign sda_o  = 1'b0;
  assign sda_oe = drive_low;
endmodule

// File: rtl/cfgreg_smbus_chk.sv
module cfgreg_smbus_chk
  import cfgsmb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic                  start_det,
  input xact_st_t              st,
  input logic [BITCNT_W-1:0]   bit_cnt,
  input logic [8*NUM_REGS-1:0] cfg_o
);
  // R9
  sda_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R6
  cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(wr_en));

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_IDLE) |-> !sda_oe);

  // R2
  start_reframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == '0 && st == XS_ADDR));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

bind cfgreg_smbus_slave cfgreg_smbus_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
  .start_det(start_det), .st(st), .bit_cnt(bit_cnt), .cfg_o(cfg_o)
);

// File: tb/cfgreg_smbus_slave_tb.sv
module cfgreg_smbus_slave_tb;
  localparam int NR = 8;
  localparam int H  = 10;

  function automatic logic [8*NR-1:0] mk_def();
    logic [8*NR-1:0] v;
    for (int i = 0; i < NR; i++) v[8*i +: 8] = 8'(8'h5A ^ (i * 19));
    return v;
  endfunction
  localparam logic [8*NR-1:0] DEF_VAL = mk_def();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_o, sda_oe, sda_line;
  logic [8*NR-1:0] cfg_o;
  logic [7:0] mdl [NR];
  int vec = 0;
  int miss = 0;

  always #2.5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  cfgreg_smbus_slave #(.NUM_REGS(NR), .DEV_ADDR(7'h6E), .RST_VAL(DEF_VAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8*NR-1:0] mdl_img();
    logic [8*NR-1:0] v;
    for (int i = 0; i < NR; i++) v[8*i +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk_img(input string req);
    chk(cfg_o == mdl_img(), req, 64'(cfg_o), 64'(mdl_img()));
  endtask

  task automatic m_start();
    m_low = 1'b0; hw(H/2); m_scl = 1'b1; hw(H);
    m_low = 1'b1; hw(H); m_scl = 1'b0; hw(H/2);
  endtask

  task automatic m_stop();
    m_low = 1'b1; hw(H/2); m_scl = 1'b1; hw(H);
    m_low = 1'b0; hw(H);
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hw(H/2); m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(H/2);
    end
    m_low = 1'b0; hw(H/2); m_scl = 1'b1; hw(H/2);
    ack = ~sda_line;
    hw(H/2); m_scl = 1'b0; hw(H/2);
  endtask

  task automatic rb(input bit nack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hw(H/2); m_scl = 1'b1; hw(H/2); b[i] = sda_line; hw(H/2); m_scl = 1'b0;
    end
    hw(H/2); m_low = ~nack; hw(H/2); m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(H/2);
    m_low = 1'b0;
  endtask

  task automatic wr_byte(input int off, input logic [7:0] d);
    bit a0, a1, a2;
    m_start(); wb(8'hDC, a0); wb(8'h80 | 8'(off), a1); wb(d, a2); m_stop();
    chk(a0 && a1 && a2, "R2 acks on byte write", {61'd0, a0, a1, a2}, 64'd7);
    if (off < NR) mdl[off] = d;
    chk_img(off < NR ? "R3 byte write image" : "R8 out-of-range write ignored");
  endtask

  task automatic rd_byte(input int off);
    bit a0, a1, a2;
    logic [7:0] r, e;
    m_start(); wb(8'hDC, a0); wb(8'h80 | 8'(off), a1);
    m_start(); wb(8'hDD, a2); rb(1'b1, r); m_stop();
    e = (off < NR) ? mdl[off] : 8'hFF;
    chk(a0 && a1 && a2, "R2 acks on byte read", {61'd0, a0, a1, a2}, 64'd7);
    chk(r == e, off < NR ? "R4 byte read data" : "R8 out-of-range read", 64'(r), 64'(e));
  endtask

  task automatic blk_wr(input logic [7:0] cmd, input int n, input logic [7:0] seed);
    bit a, all_ok;
    all_ok = 1'b1;
    m_start(); wb(8'hDC, a); all_ok &= a; wb(cmd, a); all_ok &= a;
    wb(8'(n), a); all_ok &= a;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed + 8'(i * 29));
      wb(d, a); all_ok &= a;
      if (i < NR) mdl[i] = d;
    end
    m_stop();
    chk(all_ok, "R8 every block write byte acked", 64'(all_ok), 64'd1);
    chk_img(n < NR ? "R6 early stop keeps rest" : "R5 R8 block write image");
  endtask

  task automatic blk_rd(input int m);
    bit a0, a1, a2;
    logic [7:0] r, e;
    m_start(); wb(8'hDC, a0); wb(8'h00, a1); m_start(); wb(8'hDD, a2);
    chk(a0 && a1 && a2, "R2 acks on block read", {61'd0, a0, a1, a2}, 64'd7);
    rb(1'b0, r);
    chk(r == 8'(NR), "R7 block read count", 64'(r), 64'(NR));
    for (int i = 0; i < m; i++) begin
      rb(i == m - 1, r);
      e = (i < NR) ? mdl[i] : 8'hFF;
      chk(r == e, "R7 block read data", 64'(r), 64'(e));
    end
    hw(4);
    chk(sda_oe == 1'b0, "R7 released after NACK", 64'(sda_oe), 64'd0);
    m_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] r;
    for (int i = 0; i < NR; i++) mdl[i] = DEF_VAL[8*i +: 8];
    hw(5); rst_n = 1'b1; hw(5);
    chk_img("R1 reset image");

    // R2: foreign address is not acknowledged and its traffic is dropped
    m_start(); wb(8'hA0, a);
    chk(!a, "R2 foreign address nack", 64'(a), 64'd0);
    wb(8'h81, a); wb(8'h00, a); m_stop();
    chk_img("R2 foreign write ignored");
    // R2: a repeated START after a mismatch is served again
    m_start(); wb(8'hDE, a); m_start(); wb(8'hDC, a);
    chk(a, "R2 match after restart", 64'(a), 64'd1);
    wb(8'h82, a); wb(8'h3C, a); m_stop(); mdl[2] = 8'h3C;
    chk_img("R3 write after restart");

    // R3 R8: byte writes over every offset plus two beyond the bank
    for (int o = 0; o < NR + 2; o++) wr_byte(o, 8'(8'hC3 ^ (o * 37)));
    // R4 R8: byte reads over the same range
    for (int o = 0; o < NR + 2; o++) rd_byte(o);

    // R5 R6 R8: block writes of every length; nonzero low bits still start at 0
    for (int n = 0; n < NR + 3; n++) blk_wr(8'h00, n, 8'(n * 11 + 1));
    blk_wr(8'h05, 3, 8'h90);
    // R7: block reads of several lengths
    for (int m = 1; m < NR + 3; m++) blk_rd(m);

    // R9: the address acknowledge is a full-clock low pulse
    m_start(); wb(8'hDC, a);
    chk(a, "R9 ack drives low", 64'(a), 64'd1);
    wb(8'h80, a); m_start(); wb(8'hDD, a); rb(1'b1, r); m_stop();
    chk(r == mdl[0], "R4 read after block traffic", 64'(r), 64'(mdl[0]));

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule